// File: doc/BRIEF.md
# Programmable 32-Input Interrupt Controller

The controller gathers 32 asynchronous interrupt request lines and presents them to a processor through a small register bank on a device-control bus (address, read strobe, write strobe, 32-bit write and read data). Each line is set up independently: it can latch on an edge or follow a level, it can be active-high or active-low, it can be enabled or masked, and it can be steered to either the critical or the normal interrupt output.

Software reads a raw status word, a masked status word (status AND enable) and a vector word that gives the index of the most urgent pending enabled line. It clears pending bits by writing ones to the status word. The priority direction can be flipped through a one-bit vector configuration field. Both interrupt outputs and the read data are registered.

Top module: `irqc_top`

## Requirements
- R1: After synchronous reset the enable, critical, polarity, trigger, status and vector configuration registers are zero, both interrupt outputs are low, and a read of any address outside the register set returns zero.
- R2: Writing the status register (0xC0) clears every status bit whose write-data bit is 1 and leaves every bit whose write-data bit is 0 unchanged.
- R3: Trigger register (0xC5) bit 0 makes a line level-sensitive: its status bit sets in every cycle its corrected input is active, so it sets again right after a clear while the input stays active.
- R4: Trigger bit 1 makes a line edge-sensitive: status sets only on an inactive-to-active change of the corrected input; a clear while the input stays active leaves the bit clear, and a fresh edge sets it again.
- R5: Polarity register (0xC4) bit 1 makes the line active-low, bit 0 active-high.
- R6: The masked status register (0xC6) reads as status AND enable (0xC2), and reads zero when no enabled line is pending.
- R7: The critical output is the OR of masked status bits whose critical-select bit (0xC3) is 1; the normal output is the OR of masked status bits whose critical-select bit is 0.
- R8: The vector register (0xC7) returns the index of the highest-priority set masked status bit, or all ones when none is set; with vector configuration (0xC8) bit 0 equal to 0 line 31 has highest priority, with it 1 line 0 has highest priority.
- R9: An input change reaches the status register on the third rising edge after it is applied (two synchronizer stages plus detection) and the interrupt outputs one edge later; read data appears on the edge after the read strobe and holds until the next read.
- R10: The enable, critical, polarity and trigger registers and vector configuration bit 0 read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Asynchronous interrupt request lines |
| dcr_addr | input | 10 | Register address |
| dcr_rd | input | 1 | Read strobe |
| dcr_wr | input | 1 | Write strobe |
| dcr_wdata | input | 32 | Write data |
| dcr_rdata | output | 32 | Registered read data |
| irq_norm | output | 1 | Normal interrupt request |
| irq_crit | output | 1 | Critical interrupt request |

## Verification
On every cycle the assertions check the status cell rules (a level line set while active, an edge line held clear after a clear with no new edge, no pending bit lost without a clear), the derivation of the critical output from masked pending critical lines, masked status and empty-vector read data, and zero data for undecoded reads. Latency through the synchronizers, the polarity inversion, priority reversal, the interplay of clear and re-latch on held inputs and readback of the configuration can only be shown by the bench's scenarios against its cycle model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ADDR_W = 10;
  localparam logic [ADDR_W-1:0] A_STAT  = 10'h0C0;
  localparam logic [ADDR_W-1:0] A_EN    = 10'h0C2;
  localparam logic [ADDR_W-1:0] A_CRIT  = 10'h0C3;
  localparam logic [ADDR_W-1:0] A_POL   = 10'h0C4;
  localparam logic [ADDR_W-1:0] A_TRIG  = 10'h0C5;
  localparam logic [ADDR_W-1:0] A_MSTAT = 10'h0C6;
  localparam logic [ADDR_W-1:0] A_VEC   = 10'h0C7;
  localparam logic [ADDR_W-1:0] A_VCFG  = 10'h0C8;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/irqc_line.sv
module irqc_line (
  input  logic clk,
  input  logic rst,
  input  logic sync_in,
  input  logic pol_low,
  input  logic edge_mode,
  input  logic clr,
  output logic stat
);
  logic act;
  logic prev;
  logic hit;

  assign act = sync_in ^ pol_low;
  assign hit = edge_mode ? (act & ~prev) : act;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b0;
      stat <= 1'b0;
    end else begin
      prev <= act;
      stat <= (stat & ~clr) | hit;
    end
  end

  // R3
  level_relatch_chk: assert property (@(posedge clk) disable iff (rst)
    (!edge_mode && act) |=> stat);

  // R4
  edge_hold_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_mode && act && prev && clr) |=> !stat);

  // R2
  no_lost_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (stat && !clr) |=> stat);
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  input  logic             low_first,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    if (low_first) begin
      for (int i = N - 1; i >= 0; i--) begin
        if (req[i]) begin
          found = 1'b1;
          idx   = IDX_W'(i);
        end
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (req[i]) begin
          found = 1'b1;
          idx   = IDX_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int N_LINES = 32,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_LINES-1:0] irq_in,
  input  logic [ADDR_W-1:0] dcr_addr,
  input  logic              dcr_rd,
  input  logic              dcr_wr,
  input  logic [DATA_W-1:0] dcr_wdata,
  output logic [DATA_W-1:0] dcr_rdata,
  output logic              irq_norm,
  output logic              irq_crit
);
  localparam int IDX_W = $clog2(N_LINES);

  logic [N_LINES-1:0] sync_q;
  logic [N_LINES-1:0] stat;
  logic [N_LINES-1:0] en_r, crit_r, pol_r, trig_r;
  logic               vrev_r;
  logic [N_LINES-1:0] clr_vec;
  logic [N_LINES-1:0] mstat;
  logic               vec_found;
  logic [IDX_W-1:0]   vec_idx;
  logic [DATA_W-1:0]  rd_word;
  logic               decoded;

  irqc_sync #(.W(N_LINES)) u_sync (
    .clk(clk), .rst(rst), .d(irq_in), .q(sync_q)
  );

  assign clr_vec = (dcr_wr && dcr_addr == A_STAT) ? dcr_wdata[N_LINES-1:0] : '0;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    irqc_line u_line (
      .clk(clk), .rst(rst),
      .sync_in(sync_q[g]),
      .pol_low(pol_r[g]),
      .edge_mode(trig_r[g]),
      .clr(clr_vec[g]),
      .stat(stat[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_r   <= '0;
      crit_r <= '0;
      pol_r  <= '0;
      trig_r <= '0;
      vrev_r <= 1'b0;
    end else if (dcr_wr) begin
      case (dcr_addr)
        A_EN:    en_r   <= dcr_wdata[N_LINES-1:0];
        A_CRIT:  crit_r <= dcr_wdata[N_LINES-1:0];
        A_POL:   pol_r  <= dcr_wdata[N_LINES-1:0];
        A_TRIG:  trig_r <= dcr_wdata[N_LINES-1:0];
        A_VCFG:  vrev_r <= dcr_wdata[0];
        default: ;
      endcase
    end
  end

  assign mstat = stat & en_r;

  irqc_prio #(.N(N_LINES), .IDX_W(IDX_W)) u_prio (
    .req(mstat), .low_first(vrev_r), .found(vec_found), .idx(vec_idx)
  );

  always_comb begin
    rd_word = '0;
    decoded = 1'b1;
    case (dcr_addr)
      A_STAT:  rd_word[N_LINES-1:0] = stat;
      A_EN:    rd_word[N_LINES-1:0] = en_r;
      A_CRIT:  rd_word[N_LINES-1:0] = crit_r;
      A_POL:   rd_word[N_LINES-1:0] = pol_r;
      A_TRIG:  rd_word[N_LINES-1:0] = trig_r;
      A_MSTAT: rd_word[N_LINES-1:0] = mstat;
      A_VEC: begin
        if (vec_found) rd_word[IDX_W-1:0] = vec_idx;
        else           rd_word = '1;
      end
      A_VCFG:  rd_word[0] = vrev_r;
      default: decoded = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dcr_rdata <= '0;
      irq_norm  <= 1'b0;
      irq_crit  <= 1'b0;
    end else begin
      if (dcr_rd) dcr_rdata <= rd_word;
      irq_norm <= |(mstat & ~crit_r);
      irq_crit <= |(mstat & crit_r);
    end
  end

  // R1
  undecoded_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (dcr_rd && !decoded) |=> dcr_rdata == '0);

  // R8
  empty_vector_chk: assert property (@(posedge clk) disable iff (rst)
    (dcr_rd && dcr_addr == A_VEC && mstat == '0) |=> dcr_rdata == '1);

  // R6
  masked_read_chk: assert property (@(posedge clk) disable iff (rst)
    (dcr_rd && dcr_addr == A_MSTAT) |=> dcr_rdata[N_LINES-1:0] == $past(stat & en_r));

  // R7
  crit_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq_crit |-> $past(|(stat & en_r & crit_r)));
endmodule

// File: tb/sim_irqc_top.sv
`timescale 1ns/1ps
module sim_irqc_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_in = '0;
  logic [9:0]  dcr_addr = '0;
  logic        dcr_rd = 1'b0;
  logic        dcr_wr = 1'b0;
  logic [31:0] dcr_wdata = '0;
  logic [31:0] dcr_rdata;
  logic        irq_norm, irq_crit;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit live = 0;

  // behavioural model state
  logic [31:0] m_s1, m_s2, m_prev, m_stat, m_en, m_crit, m_pol, m_trig, m_rdata;
  logic        m_rev, m_norm, m_crito;

  always #2 clk = ~clk;

  irqc_top u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in), .dcr_addr(dcr_addr),
    .dcr_rd(dcr_rd), .dcr_wr(dcr_wr), .dcr_wdata(dcr_wdata),
    .dcr_rdata(dcr_rdata), .irq_norm(irq_norm), .irq_crit(irq_crit)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [9:0] a);
    logic [31:0] ms;
    logic [31:0] v;
    ms = m_stat & m_en;
    case (a)
      10'h0C0: return m_stat;
      10'h0C2: return m_en;
      10'h0C3: return m_crit;
      10'h0C4: return m_pol;
      10'h0C5: return m_trig;
      10'h0C6: return ms;
      10'h0C7: begin
        v = 32'hFFFF_FFFF;
        if (m_rev) begin
          for (int i = 31; i >= 0; i--) if (ms[i]) v = i;
        end else begin
          for (int i = 0; i < 32; i++) if (ms[i]) v = i;
        end
        return v;
      end
      10'h0C8: return {31'd0, m_rev};
      default: return 32'd0;
    endcase
  endfunction

  task automatic tick();
    logic [31:0] act, hit, clr, rdv;
    @(posedge clk);
    #1;
    if (rst) begin
      {m_s1, m_s2, m_prev, m_stat, m_en, m_crit, m_pol, m_trig, m_rdata} = '0;
      {m_rev, m_norm, m_crito} = '0;
      live = 1;
    end else begin
      act = m_s2 ^ m_pol;
      hit = (m_trig & act & ~m_prev) | (~m_trig & act);
      clr = (dcr_wr && dcr_addr == 10'h0C0) ? dcr_wdata : 32'd0;
      rdv = model_read(dcr_addr);
      m_norm  = |(m_stat & m_en & ~m_crit);
      m_crito = |(m_stat & m_en & m_crit);
      if (dcr_rd) m_rdata = rdv;
      m_stat = (m_stat & ~clr) | hit;
      m_prev = act;
      m_s2 = m_s1;
      m_s1 = irq_in;
      if (dcr_wr) begin
        case (dcr_addr)
          10'h0C2: m_en = dcr_wdata;
          10'h0C3: m_crit = dcr_wdata;
          10'h0C4: m_pol = dcr_wdata;
          10'h0C5: m_trig = dcr_wdata;
          10'h0C8: m_rev = dcr_wdata[0];
          default: ;
        endcase
      end
    end
    @(negedge clk);
    if (live) begin
      // R9 lockstep comparison against the model every cycle
      chk("R9 lockstep", {dcr_rdata, 30'd0, irq_norm, irq_crit},
          {m_rdata, 30'd0, m_norm, m_crito});
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    dcr_addr = a; dcr_wdata = d; dcr_wr = 1'b1;
    tick();
    dcr_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    dcr_addr = a; dcr_rd = 1'b1;
    tick();
    dcr_rd = 1'b0;
    d = dcr_rdata;
  endtask

  initial begin
    logic [31:0] d;
    ticks(3);
    rst = 1'b0;
    tick();
    // R1 reset state
    chk("R1 outputs", {30'd0, irq_norm, irq_crit}, 32'd0);
    rd(10'h0C0, d); chk("R1 status", d, 0);
    rd(10'h0C2, d); chk("R1 enable", d, 0);
    rd(10'h0C5, d); chk("R1 trigger", d, 0);
    rd(10'h0C1, d); chk("R1 undecoded", d, 0);
    rd(10'h0C7, d); chk("R8 empty vector", d, 32'hFFFF_FFFF);

    // R10 readback
    wr(10'h0C2, 32'h0000_02A8); // lines 3,5,7,9 enabled
    rd(10'h0C2, d); chk("R10 enable readback", d, 32'h0000_02A8);
    wr(10'h0C3, 32'h0000_0200); // line 9 critical
    rd(10'h0C3, d); chk("R10 critical readback", d, 32'h0000_0200);

    // R9 latency on level line 3
    irq_in[3] = 1'b1;
    ticks(3);
    chk("R9 output not yet", {31'd0, irq_norm}, 0);
    tick();
    chk("R9 output after four edges", {31'd0, irq_norm}, 1);
    chk("R7 crit low for normal line", {31'd0, irq_crit}, 0);

    // R3 level relatch while asserted
    wr(10'h0C0, 32'h0000_0008);
    rd(10'h0C0, d); chk("R3 level re-sets", d & 32'h8, 32'h8);
    irq_in[3] = 1'b0;
    ticks(3);
    wr(10'h0C0, 32'h0000_0008);
    rd(10'h0C0, d); chk("R3 cleared after release", d & 32'h8, 0);
    ticks(1);
    chk("R7 normal drops", {31'd0, irq_norm}, 0);

    // R4 edge line 5
    wr(10'h0C5, 32'h0000_0020);
    rd(10'h0C5, d); chk("R10 trigger readback", d, 32'h20);
    irq_in[5] = 1'b1;
    ticks(4);
    rd(10'h0C0, d); chk("R4 edge latched", d & 32'h20, 32'h20);
    wr(10'h0C0, 32'h0000_0020);
    ticks(3);
    rd(10'h0C0, d); chk("R4 stays clear while held", d & 32'h20, 0);
    irq_in[5] = 1'b0; ticks(3);
    irq_in[5] = 1'b1; ticks(4);
    rd(10'h0C0, d); chk("R4 new edge relatches", d & 32'h20, 32'h20);
    irq_in[5] = 1'b0;

    // R2 write of zeros leaves pending bits
    wr(10'h0C0, 32'h0);
    rd(10'h0C0, d); chk("R2 zero write keeps", d & 32'h20, 32'h20);

    // R5 active-low line 7, input stays 0
    wr(10'h0C4, 32'h0000_0080);
    ticks(4);
    rd(10'h0C0, d); chk("R5 active-low latches", d & 32'h80, 32'h80);
    irq_in[7] = 1'b1; ticks(3);
    wr(10'h0C0, 32'h0000_0080);
    rd(10'h0C0, d); chk("R5 inactive high stays clear", d & 32'h80, 0);

    // R6 unenabled line 12 pending
    irq_in[12] = 1'b1; ticks(4);
    rd(10'h0C0, d); chk("R6 raw shows line 12", d & 32'h1000, 32'h1000);
    rd(10'h0C6, d); chk("R6 masked excludes line 12", d, 32'h20);

    // R7 critical line 9, R8 priorities
    irq_in[9] = 1'b1; ticks(4);
    chk("R7 critical asserted", {31'd0, irq_crit}, 1);
    rd(10'h0C7, d); chk("R8 highest is 9", d, 9);
    wr(10'h0C8, 32'h1);
    rd(10'h0C8, d); chk("R10 vcfg readback", d, 1);
    rd(10'h0C7, d); chk("R8 reversed lowest is 5", d, 5);
    irq_in[9] = 1'b0; irq_in[12] = 1'b0; ticks(3);

    // R2 write back read value clears all
    rd(10'h0C0, d);
    wr(10'h0C0, d);
    rd(10'h0C0, d); chk("R2 write-back clears", d, 0);
    rd(10'h0C6, d); chk("R6 masked zero", d, 0);
    rd(10'h0C7, d); chk("R8 none pending", d, 32'hFFFF_FFFF);
    ticks(2);
    chk("R7 both low", {30'd0, irq_norm, irq_crit}, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule